// File: doc/BRIEF.md
# Power-Down Clock Sequencer

This block controls how a multi-output clock generator goes into and comes out of its low-power state. A single internal core clock drives the block. From that clock it derives a processor-domain clock group, a bus clock group, one free-running bus clock and a reference group. Each output passes through its own glitch-free gate. The analog oscillator and the frequency synthesiser are outside the block. The block only sees them as two enable outputs and one lock input.

An active-low power-down request comes in asynchronously. It is resynchronised by two flip-flops on the core clock. When the request asserts, the sequencer stops opening gates. Each output is parked low at the end of its current high phase. Only after every gate reports closed are the oscillator and synthesiser enables removed.

When the request is released, the sequencer raises both enables. It then waits a parameterised settling count and for the lock input before any gate may open again. While the block is powered down, the per-domain stop requests have no effect.

Top module: `clkgen_pd_seq`

## Requirements
- R1: Out of reset, with the power-down request held low, `osc_en` and `pll_en` are 0 and every clock output is 0.
- R2: The power-down request passes through a two-stage synchronizer. After `pd_req_n` rises, `osc_en` and `pll_en` are still 0 following the first and second rising clock edges, and both are 1 following the third.
- R3: After `osc_en` rises, every clock output stays 0 for at least `WAKE_CYC` clock cycles. It also stays 0 for as long as `pll_lock` is low.
- R4: `osc_en` falls only in a cycle where every clock output is 0, and all outputs were also 0 in the previous cycle. After `pd_req_n` falls, both enables are 0 within 30 cycles.
- R5: Every processor-domain output is 0 from the (`CPU_HALF`+4)-th rising edge after `pd_req_n` falls, and it stays 0 until the next wake-up. With `CPU_HALF`=1 this is within three processor-clock periods of the synchronized request.
- R6: No truncated pulses on any output. Every high pulse lasts exactly the half-period of its group (`CPU_HALF`, `PCI_HALF` or `REF_HALF` core cycles). Every low pulse lasts at least that long.
- R7: While the block is powered down, toggling `cpu_stop_n` or `pci_stop_n` changes nothing: all outputs stay 0 and `osc_en` stays 0.
- R8: `cpu_stop_n`=0 parks the processor-domain group low while the bus groups keep running. `pci_stop_n`=0 parks the bus group low while `pcif_clk` keeps running.
- R9: The reference group keeps running at its nominal rate whatever the level of either stop request.
- R10: In steady running, the groups have periods of 2×`CPU_HALF`, 2×`PCI_HALF` and 2×`REF_HALF` core cycles. `pcif_clk` has the same rate as the bus group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal core clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous processor-group stop, active low |
| pci_stop_n | input | 1 | Asynchronous bus-group stop, active low |
| pll_lock | input | 1 | Synthesiser lock / stable indication |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | Synthesiser enable |
| cpu_clk | output | NCPU | Processor-domain clock outputs |
| pci_clk | output | NPCI | Stoppable bus clock outputs |
| pcif_clk | output | 1 | Free-running bus clock output |
| ref_clk | output | NREF | Reference clock outputs |

## Verification
A change on `pd_req_n` reaches the state register on the third rising edge, and the enables follow that edge directly. The bench therefore samples the enables on the falling edges after edges two and three.

Gates are updated from the current state, so every output lags the state by one further edge. The first high output after wake-up comes no earlier than `WAKE_CYC`+1 edges after `osc_en` rises. On entry, processor outputs are checked from edge `CPU_HALF`+4 onward.

Rates are measured over windows that hold a whole number of every group's period, so the number of rising transitions in each window is exact. A falling-edge monitor measures each pulse width against its group's half-period.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PARK = 2'd1,
        ST_OFF  = 2'd2,
        ST_WAKE = 2'd3
    } seq_state_e;

    // bits needed to hold the value n (at least one)
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pdseq_div.sv
module pdseq_div
    import pdseq_pkg::*;
#(
    parameter int unsigned HALF = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase,
    output logic phase_nxt
);
    localparam int unsigned CW = cnt_w(HALF - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!run) begin
            cnt_d     = '0;
            phase_nxt = 1'b0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_d     = '0;
            phase_nxt = ~phase;
        end else begin
            cnt_d     = cnt_q + 1'b1;
            phase_nxt = phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            phase <= phase_nxt;
        end
    end
endmodule

// File: rtl/pdseq_gate.sv
module pdseq_gate (
    input  logic clk,
    input  logic rst,
    input  logic phase,
    input  logic phase_nxt,
    input  logic want,
    output logic clk_out,
    output logic gate_on
);
    logic gate_q, gate_d;

    // the gate may only change while the source phase is low
    always_comb gate_d = phase ? gate_q : want;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= 1'b0;
            clk_out <= 1'b0;
        end else begin
            gate_q  <= gate_d;
            clk_out <= phase_nxt & gate_d;
        end
    end

    assign gate_on = gate_q;

    // an output edge down must coincide with the source going low
    assert_no_runt_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_out) |-> !phase);

    assert_rise_full_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> phase);
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
    import pdseq_pkg::*;
#(
    parameter int unsigned WAKE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_act,
    input  logic       all_off,
    input  logic       pll_lock,
    output seq_state_e state
);
    localparam int unsigned WW = cnt_w(WAKE_CYC);

    seq_state_e    state_d;
    logic [WW-1:0] wcnt_q;
    logic          settled;

    assign settled = (wcnt_q == WW'(WAKE_CYC - 1));

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN:  if (pd_act) state_d = ST_PARK;
            ST_PARK: if (all_off) state_d = ST_OFF;
            ST_OFF:  if (!pd_act) state_d = ST_WAKE;
            ST_WAKE: begin
                if (pd_act) state_d = ST_PARK;
                else if (settled && pll_lock) state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_OFF;
            wcnt_q <= '0;
        end else begin
            state <= state_d;
            if (state == ST_WAKE) begin
                if (!settled) wcnt_q <= wcnt_q + 1'b1;
            end else begin
                wcnt_q <= '0;
            end
        end
    end

    assert_run_after_settle_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && state_d == ST_RUN) |-> (settled && pll_lock));
endmodule

// File: rtl/clkgen_pd_seq.sv
module clkgen_pd_seq
    import pdseq_pkg::*;
#(
    parameter int unsigned NCPU     = 4,
    parameter int unsigned NPCI     = 7,
    parameter int unsigned NREF     = 3,
    parameter int unsigned CPU_HALF = 1,
    parameter int unsigned PCI_HALF = 2,
    parameter int unsigned REF_HALF = 5,
    parameter int unsigned WAKE_CYC = 400000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pd_req_n,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic            pll_lock,
    output logic            osc_en,
    output logic            pll_en,
    output logic [NCPU-1:0] cpu_clk,
    output logic [NPCI-1:0] pci_clk,
    output logic            pcif_clk,
    output logic [NREF-1:0] ref_clk
);
    localparam int unsigned NOUT     = NCPU + NPCI + 1 + NREF;
    localparam int unsigned PCI_BASE = NCPU;
    localparam int unsigned PCIF_IDX = NCPU + NPCI;
    localparam int unsigned REF_BASE = NCPU + NPCI + 1;
    localparam int unsigned PCW      = cnt_w(CPU_HALF + 1);

    logic            pd_ok, cpu_go, pci_go;
    seq_state_e      state;
    logic [NOUT-1:0] gate_on;
    logic            all_off;
    logic            cpu_ph, cpu_ph_nxt, pci_ph, pci_ph_nxt, ref_ph, ref_ph_nxt;
    logic            want_cpu, want_pci, want_run;
    logic [PCW-1:0]  park_cnt;
    logic [NOUT-1:0] outs_all;

    // power-down sync resets to "request active"
    pdseq_sync #(.RST_VAL(1'b0)) u_sync_pd  (.clk(clk), .rst(rst), .d(pd_req_n),   .q(pd_ok));
    pdseq_sync #(.RST_VAL(1'b1)) u_sync_cpu (.clk(clk), .rst(rst), .d(cpu_stop_n), .q(cpu_go));
    pdseq_sync #(.RST_VAL(1'b1)) u_sync_pci (.clk(clk), .rst(rst), .d(pci_stop_n), .q(pci_go));

    assign all_off = ~|gate_on;

    pdseq_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .pd_act(!pd_ok), .all_off(all_off),
        .pll_lock(pll_lock), .state(state)
    );

    assign osc_en = (state != ST_OFF);
    assign pll_en = (state != ST_OFF);

    // stop requests only matter while running; power-down overrides them
    assign want_run = (state == ST_RUN);
    assign want_cpu = want_run && cpu_go;
    assign want_pci = want_run && pci_go;

    pdseq_div #(.HALF(CPU_HALF)) u_div_cpu (.clk(clk), .rst(rst), .run(pll_en),
        .phase(cpu_ph), .phase_nxt(cpu_ph_nxt));
    pdseq_div #(.HALF(PCI_HALF)) u_div_pci (.clk(clk), .rst(rst), .run(pll_en),
        .phase(pci_ph), .phase_nxt(pci_ph_nxt));
    pdseq_div #(.HALF(REF_HALF)) u_div_ref (.clk(clk), .rst(rst), .run(osc_en),
        .phase(ref_ph), .phase_nxt(ref_ph_nxt));

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        pdseq_gate u_gate (.clk(clk), .rst(rst), .phase(cpu_ph), .phase_nxt(cpu_ph_nxt),
            .want(want_cpu), .clk_out(cpu_clk[i]), .gate_on(gate_on[i]));
    end

    for (genvar i = 0; i < NPCI; i++) begin : g_pci
        pdseq_gate u_gate (.clk(clk), .rst(rst), .phase(pci_ph), .phase_nxt(pci_ph_nxt),
            .want(want_pci), .clk_out(pci_clk[i]), .gate_on(gate_on[PCI_BASE+i]));
    end

    pdseq_gate u_gate_pcif (.clk(clk), .rst(rst), .phase(pci_ph), .phase_nxt(pci_ph_nxt),
        .want(want_run), .clk_out(pcif_clk), .gate_on(gate_on[PCIF_IDX]));

    for (genvar i = 0; i < NREF; i++) begin : g_ref
        pdseq_gate u_gate (.clk(clk), .rst(rst), .phase(ref_ph), .phase_nxt(ref_ph_nxt),
            .want(want_run), .clk_out(ref_clk[i]), .gate_on(gate_on[REF_BASE+i]));
    end

    // cycles spent in PARK, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            park_cnt <= '0;
        end else if (state == ST_PARK) begin
            if (park_cnt != PCW'(CPU_HALF + 1)) park_cnt <= park_cnt + 1'b1;
        end else begin
            park_cnt <= '0;
        end
    end

    assign outs_all = {ref_clk, pcif_clk, pci_clk, cpu_clk};

    assert_osc_after_park_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en) |-> (outs_all == '0 && $past(outs_all) == '0));

    assert_cpu_park_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARK && park_cnt == PCW'(CPU_HALF + 1)) |-> (cpu_clk == '0));

    assert_off_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF) |-> (outs_all == '0));

    assert_wake_closed_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE) |-> (gate_on == '0 && outs_all == '0));
endmodule

// File: tb/clkgen_pd_seq_bench.sv
module clkgen_pd_seq_bench;
    localparam int NCPU = 4, NPCI = 7, NREF = 3;
    localparam int CH = 1, PH = 2, RH = 3, WC = 20;
    localparam int NOUT = NCPU + NPCI + 1 + NREF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_req_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pll_lock = 1'b0;
    logic osc_en, pll_en, pcif_clk;
    logic [NCPU-1:0] cpu_clk;
    logic [NPCI-1:0] pci_clk;
    logic [NREF-1:0] ref_clk;
    logic [NOUT-1:0] outs;

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clkgen_pd_seq #(.NCPU(NCPU), .NPCI(NPCI), .NREF(NREF), .CPU_HALF(CH),
        .PCI_HALF(PH), .REF_HALF(RH), .WAKE_CYC(WC)) u_clkgen_pd_seq (
        .clk(clk), .rst(rst), .pd_req_n(pd_req_n), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .pll_lock(pll_lock), .osc_en(osc_en), .pll_en(pll_en),
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pcif_clk(pcif_clk), .ref_clk(ref_clk));

    assign outs = {ref_clk, pcif_clk, pci_clk, cpu_clk};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int half_of(input int idx);
        if (idx < NCPU) return CH;
        if (idx < NCPU + NPCI + 1) return PH;
        return RH;
    endfunction

    // pulse-width monitor (R6) and oscillator shut-off monitor (R4)
    int hi_run[NOUT];
    int lo_run[NOUT];
    logic [NOUT-1:0] prev_o = '0;
    logic prev_osc = 1'b0;

    initial for (int i = 0; i < NOUT; i++) begin hi_run[i] = 0; lo_run[i] = 100; end

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NOUT; i++) begin
                if (outs[i]) begin
                    if (!prev_o[i]) begin
                        check(lo_run[i] >= half_of(i), "R6 low pulse", lo_run[i], half_of(i));
                        hi_run[i] = 1;
                    end else hi_run[i]++;
                end else begin
                    if (prev_o[i]) begin
                        check(hi_run[i] == half_of(i), "R6 high pulse", hi_run[i], half_of(i));
                        lo_run[i] = 1;
                    end else lo_run[i]++;
                end
            end
            if (prev_osc && !osc_en)
                check(outs == '0 && prev_o == '0, "R4 osc_en fell with a clock high",
                      int'(outs | prev_o), 0);
        end
        prev_o   = outs;
        prev_osc = osc_en;
    end

    int rc_cpu, rc_pci, rc_pcif, rc_ref;
    bit any_cpu, any_pci, any_ref, any_out;

    task automatic window(input int n);
        logic p0, p1, p2, p3;
        rc_cpu = 0; rc_pci = 0; rc_pcif = 0; rc_ref = 0;
        any_cpu = 0; any_pci = 0; any_ref = 0; any_out = 0;
        p0 = cpu_clk[0]; p1 = pci_clk[0]; p2 = pcif_clk; p3 = ref_clk[0];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cpu_clk[0] && !p0) rc_cpu++;
            if (pci_clk[0] && !p1) rc_pci++;
            if (pcif_clk && !p2) rc_pcif++;
            if (ref_clk[0] && !p3) rc_ref++;
            any_cpu |= |cpu_clk;
            any_pci |= |pci_clk;
            any_ref |= |ref_clk;
            any_out |= |outs;
            p0 = cpu_clk[0]; p1 = pci_clk[0]; p2 = pcif_clk; p3 = ref_clk[0];
        end
    endtask

    task automatic pd_cycle(input int off);
        bit bad;
        repeat (off) @(negedge clk);
        pd_req_n = 1'b0;
        bad = 0;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (k >= CH + 4 && cpu_clk != '0) bad = 1;
        end
        check(!bad, "R5 cpu outputs parked late", int'(bad), 0);
        check(!osc_en && !pll_en, "R4 enables still high after entry", int'({osc_en, pll_en}), 0);
        // stop requests toggled while powered down
        any_out = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            cpu_stop_n = ~cpu_stop_n;
            if (k % 3 == 0) pci_stop_n = ~pci_stop_n;
            any_out |= (|outs) | osc_en;
        end
        check(!any_out, "R7 activity while powered down", int'(any_out), 0);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (4) @(negedge clk);
        pd_req_n = 1'b1;
        @(negedge clk);
        check(!osc_en, "R2 osc_en after edge 1", int'(osc_en), 0);
        @(negedge clk);
        check(!osc_en, "R2 osc_en after edge 2", int'(osc_en), 0);
        @(negedge clk);
        check(osc_en && pll_en, "R2 enables after edge 3", int'({osc_en, pll_en}), 3);
        any_out = |outs;
        window(WC - 1);
        check(!any_out, "R3 output during settling", int'(any_out), 0);
        window(24);
        check(rc_cpu > 0 && rc_ref > 0, "R3 clocks resumed", rc_cpu, 12);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1
        any_out = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            any_out |= (|outs) | osc_en | pll_en;
        end
        check(!any_out, "R1 reset state", int'(any_out), 0);
        // R2 first wake-up
        pd_req_n = 1'b1;
        @(negedge clk);
        check(!osc_en, "R2 osc_en after edge 1", int'(osc_en), 0);
        @(negedge clk);
        check(!osc_en && !pll_en, "R2 enables after edge 2", int'({osc_en, pll_en}), 0);
        @(negedge clk);
        check(osc_en && pll_en, "R2 enables after edge 3", int'({osc_en, pll_en}), 3);
        // R3 lock held low
        window(40);
        check(!any_out, "R3 outputs while lock low", int'(any_out), 0);
        pll_lock = 1'b1;
        window(20);
        check(any_cpu, "R3 run after lock", int'(any_cpu), 1);
        // R10 rates over 120 cycles (multiple of 2, 4, 6)
        window(120);
        check(rc_cpu == 120 / (2 * CH), "R10 cpu rate", rc_cpu, 120 / (2 * CH));
        check(rc_pci == 120 / (2 * PH), "R10 pci rate", rc_pci, 120 / (2 * PH));
        check(rc_pcif == 120 / (2 * PH), "R10 pcif rate", rc_pcif, 120 / (2 * PH));
        check(rc_ref == 120 / (2 * RH), "R10 ref rate", rc_ref, 120 / (2 * RH));
        // R8 / R9 processor stop
        cpu_stop_n = 1'b0;
        repeat (10) @(negedge clk);
        window(24);
        check(!any_cpu, "R8 cpu stopped", int'(any_cpu), 0);
        check(rc_pci == 6 && rc_pcif == 6, "R8 bus runs during cpu stop", rc_pci, 6);
        check(rc_ref == 4, "R9 ref during cpu stop", rc_ref, 4);
        cpu_stop_n = 1'b1;
        repeat (10) @(negedge clk);
        window(24);
        check(rc_cpu == 12, "R8 cpu restarts", rc_cpu, 12);
        // bus stop
        pci_stop_n = 1'b0;
        repeat (10) @(negedge clk);
        window(24);
        check(!any_pci, "R8 pci stopped", int'(any_pci), 0);
        check(rc_pcif == 6, "R8 pcif free-running", rc_pcif, 6);
        check(rc_cpu == 12, "R8 cpu runs during pci stop", rc_cpu, 12);
        check(rc_ref == 4, "R9 ref during pci stop", rc_ref, 4);
        pci_stop_n = 1'b1;
        repeat (10) @(negedge clk);
        window(24);
        check(rc_pci == 6, "R8 pci restarts", rc_pci, 6);
        // R4 / R5 / R7 entry sweep over every phase alignment
        for (int off = 0; off < 12; off++) pd_cycle(off);
        // power-down while a stop is active
        cpu_stop_n = 1'b0;
        repeat (6) @(negedge clk);
        pd_cycle(3);
        cpu_stop_n = 1'b1;
        repeat (10) @(negedge clk);
        window(24);
        check(rc_cpu == 12, "R8 cpu after stop and power cycle", rc_cpu, 12);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule